// File: doc/BRIEF.md
# Circulating-Buffer Text Terminal

This block is a character display terminal whose text is held in a rotating shift ring instead of an addressable frame buffer. A page ring of COLS x ROWS seven-bit character slots recirculates in step with the raster. On the last scanline of each text row, the slots of the next row pass the ring's tap and are copied into a one-row line ring. The line ring rotates once per character cell, so the same row is redrawn for all eight scanlines. The character at the line ring's tap is turned into a pixel by a built-in 3x5 glyph table, using the beam position within the 8x8 cell.

A processor writes 7-bit ASCII through a strobe and watches a ready flag. A printable character is held until its cursor slot comes past the page tap, and it is written in there. That is the only point at which the block takes new text. Carriage return moves the cursor down. Other control codes are dropped. Moving past the last row scrolls the page by giving the ring one extra row of rotation during vertical blanking. The row that now sits at the bottom is cleared to spaces the next time it is loaded.

The beam counters come from an external sync generator. The generator must sweep the full raster in order, and each frame must include at least one blanking line below the text area that lasts at least COLS clocks.

Top module: `circ_text_term`

## Requirements
- R1: After reset every slot holds a space (0x20), the cursor is at row 0, column 0, and ready stays low until the beam has been at hpos = 0, vpos = 0. Ready is high from the next cycle on, which is within one frame.
- R2: Inside the text area (hpos < COLS*8, vpos < ROWS*8) the character cell is column hpos/8, row vpos/8. A glyph occupies cell pixels x = 2..4 and y = 1..5. Dot = bit 14 - ((y-1)*3 + (x-2)) of the 15-bit glyph, where bit 14 is the top-left pixel. Every other pixel of the cell is 0.
- R3: Codes 0x30-0x39 and 0x41-0x5A have glyphs. Every other code, including space and lowercase letters, renders as all zeros.
- R4: Dot is 0 whenever hpos >= COLS*8 or vpos >= ROWS*8.
- R5: A write is accepted on a clock edge with wr_en and ready both high. Ready is low in the following cycle. A strobe while ready is low changes neither the text nor the cursor.
- R6: An accepted code from 0x20 to 0x7E is stored at the cursor, and the cursor moves one column right. From the last column the cursor moves to column 0 of the next row.
- R7: An accepted 0x0D stores nothing and moves the cursor to column 0 of the next row.
- R8: Any other accepted code below 0x20, and 0x7F, is discarded and leaves the cursor unchanged. Ready is low for exactly one cycle and high again in the second cycle after the accepting edge.
- R9: When the cursor advances past the last row, every row moves up by one and the oldest row is lost. The bottom row becomes all spaces, and the cursor ends at column 0 of the last row.
- R10: After a printable write, ready returns high within one frame. After a write that causes a scroll, ready returns high within three frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the beam advances one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| hpos | input | POS_W | Horizontal beam position from the sync generator |
| vpos | input | POS_W | Vertical beam position from the sync generator |
| wr_en | input | 1 | Character write strobe |
| wr_char | input | 7 | ASCII character to write |
| ready | output | 1 | High when a write can be accepted |
| dot | output | 1 | Pixel output for the current beam position |

## Verification
The bench uses an 8x4 page and compares every pixel of whole frames against a character grid and font model. Each of those comparisons would catch a design whose line ring and page ring have drifted apart, and such a design would show text shifted by one cell or one row. The bench fills the last column of the last row and also sends carriage return on the last row, which forces a scroll. A scroll that blanked the wrong row, or left the dropped row in place, would show stale characters at the bottom. The bench also sends a second strobe while the block is busy, plus BEL and DEL codes. A design that did not ignore these would print a stray letter or move the cursor one place too far.

// File: rtl/circ_text_term.sv
module circ_text_term #(
  parameter int COLS  = 32,
  parameter int ROWS  = 30,
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] vpos,
  input  logic             wr_en,
  input  logic [6:0]       wr_char,
  output logic             ready,
  output logic             dot
);
  localparam int CELLS = COLS * ROWS;
  localparam int CW    = $clog2(COLS);
  localparam int RW    = $clog2(ROWS);
  localparam logic [POS_W-1:0] VIS_W    = POS_W'(COLS * 8);
  localparam logic [POS_W-1:0] VIS_H    = POS_W'(ROWS * 8);
  localparam logic [POS_W-1:0] LAST_ROW = POS_W'(ROWS - 1);
  localparam logic [6:0] BLANK = 7'h20;

  logic [6:0]    page [CELLS];
  logic [6:0]    line [COLS];
  logic          synced, pend_v, scroll_pend, scroll_run, clear_pend;
  logic [6:0]    pend_ch;
  logic [CW-1:0] ccol, scnt;
  logic [RW-1:0] crow;

  function automatic logic [14:0] glyph_of(input logic [6:0] c);
    case (c)
      7'h30: glyph_of = 15'h7B6F;  7'h31: glyph_of = 15'h2C97;
      7'h32: glyph_of = 15'h73E7;  7'h33: glyph_of = 15'h73CF;
      7'h34: glyph_of = 15'h5BC9;  7'h35: glyph_of = 15'h79CF;
      7'h36: glyph_of = 15'h79EF;  7'h37: glyph_of = 15'h7249;
      7'h38: glyph_of = 15'h7BEF;  7'h39: glyph_of = 15'h7BCF;
      7'h41: glyph_of = 15'h2BED;  7'h42: glyph_of = 15'h6BAE;
      7'h43: glyph_of = 15'h3923;  7'h44: glyph_of = 15'h6B6E;
      7'h45: glyph_of = 15'h79A7;  7'h46: glyph_of = 15'h79A4;
      7'h47: glyph_of = 15'h396B;  7'h48: glyph_of = 15'h5BED;
      7'h49: glyph_of = 15'h7497;  7'h4A: glyph_of = 15'h126A;
      7'h4B: glyph_of = 15'h5BAD;  7'h4C: glyph_of = 15'h4927;
      7'h4D: glyph_of = 15'h5FED;  7'h4E: glyph_of = 15'h6B6D;
      7'h4F: glyph_of = 15'h2B6A;  7'h50: glyph_of = 15'h6BA4;
      7'h51: glyph_of = 15'h2B73;  7'h52: glyph_of = 15'h6BAD;
      7'h53: glyph_of = 15'h388E;  7'h54: glyph_of = 15'h7492;
      7'h55: glyph_of = 15'h5B6F;  7'h56: glyph_of = 15'h5B6A;
      7'h57: glyph_of = 15'h5BFD;  7'h58: glyph_of = 15'h5AAD;
      7'h59: glyph_of = 15'h5A92;  7'h5A: glyph_of = 15'h72A7;
      default: glyph_of = 15'h0000;
    endcase
  endfunction

  wire in_area = (hpos < VIS_W) && (vpos < VIS_H);
  wire [POS_W-1:0] hcell = hpos >> 3;
  wire [POS_W-1:0] vrow  = vpos >> 3;
  wire [POS_W-1:0] load_row = (vrow == LAST_ROW) ? '0 : vrow + 1'b1;

  wire step      = synced && in_area && (hpos[2:0] == 3'd7);
  wire load_scan = step && (vpos[2:0] == 3'd7);

  wire is_ctl   = (pend_ch < 7'h20) || (pend_ch == 7'h7F);
  wire ctl_done = pend_v && is_ctl;
  wire hit = load_scan && pend_v && !is_ctl &&
             (load_row == POS_W'(crow)) && (hcell == POS_W'(ccol));
  wire clr = load_scan && clear_pend && (load_row == LAST_ROW);

  wire [6:0] feed = clr ? BLANK : (hit ? pend_ch : page[0]);
  wire shift_page = load_scan || scroll_run;
  wire shift_line = step || scroll_run;

  wire accept  = wr_en && ready;
  wire newline = (ctl_done && pend_ch == 7'h0D) || (hit && ccol == CW'(COLS - 1));

  assign ready = synced && !pend_v && !scroll_pend && !clear_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CELLS; i++) page[i] <= BLANK;
    end else if (shift_page) begin
      for (int i = 0; i < CELLS - 1; i++) page[i] <= page[i+1];
      page[CELLS-1] <= feed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < COLS; i++) line[i] <= BLANK;
    end else if (shift_line) begin
      for (int i = 0; i < COLS - 1; i++) line[i] <= line[i+1];
      line[COLS-1] <= shift_page ? feed : line[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synced      <= 1'b0;
      pend_v      <= 1'b0;
      pend_ch     <= '0;
      ccol        <= '0;
      crow        <= '0;
      scroll_pend <= 1'b0;
      scroll_run  <= 1'b0;
      clear_pend  <= 1'b0;
      scnt        <= '0;
    end else begin
      if (hpos == '0 && vpos == '0) synced <= 1'b1;

      if (accept) begin
        pend_v  <= 1'b1;
        pend_ch <= wr_char;
      end
      if (ctl_done || hit) pend_v <= 1'b0;

      if (newline) begin
        ccol <= '0;
        if (crow == RW'(ROWS - 1)) scroll_pend <= 1'b1;
        else                       crow <= crow + 1'b1;
      end else if (hit) begin
        ccol <= ccol + 1'b1;
      end

      if (scroll_pend && !scroll_run && synced && vpos == VIS_H && hpos == '0) begin
        scroll_run <= 1'b1;
        scnt       <= '0;
      end else if (scroll_run) begin
        scnt <= scnt + 1'b1;
        if (scnt == CW'(COLS - 1)) begin
          scroll_run  <= 1'b0;
          scroll_pend <= 1'b0;
          clear_pend  <= 1'b1;
        end
      end

      if (clr && hcell == POS_W'(COLS - 1)) clear_pend <= 1'b0;
    end
  end

  wire [2:0]  px = hpos[2:0];
  wire [2:0]  py = vpos[2:0];
  wire        in_glyph = (px >= 3'd2) && (px <= 3'd4) && (py >= 3'd1) && (py <= 3'd5);
  wire [3:0]  gidx  = 4'd14 - (4'(py - 3'd1) * 4'd3 + 4'(px - 3'd2));
  wire [14:0] gbits = glyph_of(line[0]);

  assign dot = in_area && in_glyph && gbits[gidx];
endmodule

// File: rtl/term_checks.sv
module term_checks #(
  parameter int COLS  = 32,
  parameter int ROWS  = 30,
  parameter int POS_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [POS_W-1:0] hpos,
  input logic [POS_W-1:0] vpos,
  input logic             wr_en,
  input logic [6:0]       wr_char,
  input logic             ready,
  input logic             dot
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else if (hpos == '0 && vpos == '0) seen <= 1'b1;
  end

  wire discard_code = (wr_char < 7'h20 && wr_char != 7'h0D) || wr_char == 7'h7F;

  assert_wait_for_frame_R1: assert property (@(posedge clk) disable iff (rst)
    !seen |-> !ready);

  assert_margin_dark_R2: assert property (@(posedge clk) disable iff (rst)
    (hpos[2:0] < 3'd2 || hpos[2:0] > 3'd4 || vpos[2:0] == 3'd0 || vpos[2:0] > 3'd5) |-> !dot);

  assert_blank_outside_R4: assert property (@(posedge clk) disable iff (rst)
    (hpos >= POS_W'(COLS * 8) || vpos >= POS_W'(ROWS * 8)) |-> !dot);

  assert_busy_after_write_R5: assert property (@(posedge clk) disable iff (rst)
    (ready && wr_en) |=> !ready);

  assert_discard_quick_R8: assert property (@(posedge clk) disable iff (rst)
    (ready && wr_en && discard_code) |=> !ready ##1 ready);
endmodule

bind circ_text_term term_checks #(.COLS(COLS), .ROWS(ROWS), .POS_W(POS_W)) u_checks (.*);

// File: tb/sim_circ_text_term.sv
`timescale 1ns/1ps
module sim_circ_text_term;
  localparam int COLS = 8, ROWS = 4, POS_W = 9;
  localparam int H_TOTAL = 72, V_TOTAL = 36, FRAME = H_TOTAL * V_TOTAL;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [6:0] wr_char = '0;
  logic [POS_W-1:0] hpos = 9'd10, vpos = 9'd20;
  wire ready, dot;

  always #2 clk = ~clk;

  circ_text_term #(.COLS(COLS), .ROWS(ROWS), .POS_W(POS_W)) u0 (
    .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos),
    .wr_en(wr_en), .wr_char(wr_char), .ready(ready), .dot(dot));

  localparam logic [14:0] FONT [36] = '{
    15'h7B6F, 15'h2C97, 15'h73E7, 15'h73CF, 15'h5BC9, 15'h79CF, 15'h79EF, 15'h7249,
    15'h7BEF, 15'h7BCF, 15'h2BED, 15'h6BAE, 15'h3923, 15'h6B6E, 15'h79A7, 15'h79A4,
    15'h396B, 15'h5BED, 15'h7497, 15'h126A, 15'h5BAD, 15'h4927, 15'h5FED, 15'h6B6D,
    15'h2B6A, 15'h6BA4, 15'h2B73, 15'h6BAD, 15'h388E, 15'h7492, 15'h5B6F, 15'h5B6A,
    15'h5BFD, 15'h5AAD, 15'h5A92, 15'h72A7};

  int tests = 0, fails = 0;
  logic [6:0] grid [ROWS][COLS];
  int cur_r = 0, cur_c = 0;
  bit done = 0;

  initial forever begin
    @(posedge clk); #1;
    if (hpos == H_TOTAL - 1) begin
      hpos = 0;
      vpos = (vpos == V_TOTAL - 1) ? 0 : vpos + 1;
    end else hpos = hpos + 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_dot(input int h, input int v);
    int px, py, ch;
    logic [14:0] g;
    if (h >= COLS * 8 || v >= ROWS * 8) return 0;
    ch = grid[v / 8][h / 8];
    px = h % 8; py = v % 8;
    if (px < 2 || px > 4 || py < 1 || py > 5) return 0;
    if (ch >= 48 && ch <= 57) g = FONT[ch - 48];
    else if (ch >= 65 && ch <= 90) g = FONT[ch - 55];
    else return 0;
    return g[14 - ((py - 1) * 3 + (px - 2))];
  endfunction

  task automatic frame_check(input string req);
    int bad = 0, bh = 0, bv = 0, ba = 0, be = 0;
    @(negedge clk);
    while (!(hpos == 0 && vpos == 0)) @(negedge clk);
    for (int k = 0; k < FRAME; k++) begin
      if (k > 0) @(negedge clk);
      if (dot !== exp_dot(hpos, vpos)) begin
        if (bad == 0) begin bh = hpos; bv = vpos; ba = dot; be = exp_dot(hpos, vpos); end
        bad++;
      end
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s dot at (%0d,%0d), %0d bad pixels: got %0d expected %0d", req, bh, bv, bad, ba, be);
    end
  endtask

  function automatic void model_newline();
    cur_c = 0;
    if (cur_r == ROWS - 1) begin
      for (int r = 0; r < ROWS - 1; r++)
        for (int c = 0; c < COLS; c++) grid[r][c] = grid[r+1][c];
      for (int c = 0; c < COLS; c++) grid[ROWS-1][c] = 7'h20;
    end else cur_r++;
  endfunction

  task automatic put(input logic [6:0] ch);
    bit discard, scrolls;
    int n;
    while (!ready) @(negedge clk);
    discard = (ch < 7'h20 && ch != 7'h0D) || ch == 7'h7F;
    scrolls = (cur_r == ROWS - 1) && (ch == 7'h0D || (!discard && cur_c == COLS - 1));
    wr_en = 1'b1; wr_char = ch;
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R5", "ready after accepted write", ready, 0);
    if (ch == 7'h0D) model_newline();
    else if (!discard) begin
      grid[cur_r][cur_c] = ch;
      if (cur_c == COLS - 1) model_newline(); else cur_c++;
    end
    if (discard) begin
      @(negedge clk);
      check(ready == 1'b1, "R8", "ready two cycles after discarded code", ready, 1);
    end else begin
      n = 0;
      while (!ready && n < (scrolls ? 3 * FRAME : FRAME)) begin @(negedge clk); n++; end
      check(ready == 1'b1, "R10", "ready returned within bound", ready, 1);
    end
  endtask

  task automatic put_str(input string s);
    for (int i = 0; i < s.len(); i++) put(s[i]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) grid[r][c] = 7'h20;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R1", "ready before frame start", ready, 0);
    check(dot == 1'b0, "R1", "dot after reset", dot, 0);
    while (!(hpos == 0 && vpos == 0)) @(negedge clk);
    check(ready == 1'b0, "R1", "ready at first frame origin", ready, 0);
    @(negedge clk);
    check(ready == 1'b1, "R1", "ready one cycle after origin", ready, 1);
    frame_check("R1 blank page");

    put_str("HI09AZq#");
    frame_check("R2 R3 R6 glyphs and wrap");

    put(7'h07);
    put("B");
    put(7'h0D);
    frame_check("R6 R7 R8 control codes");

    while (!ready) @(negedge clk);
    wr_en = 1'b1; wr_char = "C";
    @(posedge clk); #1 wr_char = "Z";
    @(posedge clk); #1 wr_en = 1'b0;
    grid[cur_r][cur_c] = "C"; cur_c++;
    put(7'h7F);
    put("D");
    frame_check("R5 busy strobe ignored, R8 delete");

    put(7'h0D);
    put_str("12345678");
    frame_check("R9 scroll after last column");
    check(cur_r == ROWS - 1 && cur_c == 0, "R9", "model cursor", cur_c, 0);

    put(7'h0D);
    put("E");
    frame_check("R7 R9 return on last row scrolls");

    finish_run();
  end
endmodule